// File: doc/BRIEF.md
# Sequential Unsigned Multiply-Step Engine with Early-Out

This block multiplies two 32-bit unsigned operands over several clock cycles, retiring one multiplier bit per clock through a single add-and-shift step, in the manner of a processor's multiply-step datapath. A one-cycle `start` strobe captures both operands. `busy` stays high while the sequence runs. `done` pulses once when the 64-bit product is ready on `prod_hi` (upper word) and `prod_lo` (lower word). Two flags come with the product. `zero_flag` reports an empty upper word. `ovf_flag` reports that the product does not fit in 32 bits.

The step logic shifts the exclusive-OR of its negative and overflow flags into the top of the partial product, so it treats bit 31 as a sign bit. On the full-length run the engine compensates for this: when bit 31 of the multiplicand is set, it adds operand A into the upper word. When no bit above bit 11 is set in either operand, the engine takes a shortened run of 12 steps plus a closing shift. It then realigns the result, and the upper word is zero. A final cycle assembles the result and registers it.

Top module: `mstep_mul`

## Requirements
- R1: When `done` is high, `{prod_hi, prod_lo}` equals the full 64-bit unsigned product of the `op_a` and `op_b` captured at the accepted start.
- R2: The engine uses the short run when bits 12 to 31 of `op_a` OR `op_b` are all zero, and the long run otherwise. `done` rises 14 clocks after the accepting edge on the short run, and 34 clocks after it on the long run.
- R3: On the short run, `prod_hi` is zero and `zero_flag` is 1. This covers the 12-bit boundary operands 0xFFF × 0xFFF = 0xFFE001.
- R4: `zero_flag` is 1 exactly when `prod_hi` is zero, and `ovf_flag` is always its inverse.
- R5: The long run gives the correct unsigned product when bit 31 of either operand is set. This covers 0xFFFFFFFF × 0xFFFFFFFF and 2 × 0x80000000.
- R6: A `start` that arrives while `busy` is high has no effect. The running product, its latency and the single `done` pulse are unchanged.
- R7: `busy` rises on the clock after an accepted start and is low when `done` is high. `done` lasts exactly one cycle.
- R8: `prod_hi`, `prod_lo`, `zero_flag` and `ovf_flag` hold their values in every cycle where `done` is low.
- R9: After reset, `busy` = 0, `done` = 0, `prod_hi` = `prod_lo` = 0, `zero_flag` = 1 and `ovf_flag` = 0. The reset is asynchronous and is released through a two-stage synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Operand capture strobe; accepted only while idle |
| op_a | input | 32 | Multiplier operand, loaded into the shift register |
| op_b | input | 32 | Multiplicand operand, added on each step |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse: product valid |
| prod_hi | output | 32 | Upper 32 bits of the product |
| prod_lo | output | 32 | Lower 32 bits of the product |
| zero_flag | output | 1 | Upper word is zero |
| ovf_flag | output | 1 | Product exceeds 32 bits |

## Verification
The assertions check these properties on every cycle:
- The product matches a reference multiplication of the captured operands.
- The done latency matches the path chosen from those operands.
- The two flags agree with the upper word.
- `done` is a single-cycle pulse and never occurs while busy.
- The result registers stay still between pulses.

Some behaviour only the bench's scenarios can show. These are the specific operand patterns that exercise the sign-style correction and the 12-bit boundary, the proof that a start during a run leaves no trace, the exact reset values, and recovery from a reset asserted in the middle of a run.

// File: rtl/mstep_pkg.sv
package mstep_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_STEP = 2'd1,
    ST_FIX  = 2'd2
  } mstep_state_e;

  typedef struct packed {
    logic neg;
    logic ovf;
  } mstep_cc_t;

endpackage

// File: rtl/mstep_ctrl.sv
module mstep_ctrl #(
  parameter int WIDTH      = 32,
  parameter int SHORT_BITS = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic short_sel,
  output logic load,
  output logic step_en,
  output logic final_step,
  output logic fix_en,
  output logic short_q,
  output logic busy
);
  import mstep_pkg::*;

  localparam int LONG_STEPS  = WIDTH + 1;
  localparam int SHORT_STEPS = SHORT_BITS + 1;
  localparam int CNT_W       = $clog2(LONG_STEPS + 1);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_STEPS - 1);
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_STEPS - 1);

  mstep_state_e      state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              short_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    short_d = short_q;
    load    = 1'b0;
    step_en = 1'b0;
    fix_en  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          load    = 1'b1;
          state_d = ST_STEP;
          cnt_d   = short_sel ? SHORT_LAST : LONG_LAST;
          short_d = short_sel;
        end
      end
      ST_STEP: begin
        step_en = 1'b1;
        if (cnt_q == '0) begin
          state_d = ST_FIX;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_FIX: begin
        fix_en  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      short_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      short_q <= short_d;
    end
  end

  assign final_step = (state_q == ST_STEP) && (cnt_q == '0);
  assign busy       = (state_q != ST_IDLE);

endmodule

// File: rtl/mstep_step.sv
module mstep_step #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step_en,
  input  logic             final_step,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] pp,
  output logic [WIDTH-1:0] yreg,
  output logic [WIDTH-1:0] a_hold,
  output logic             b_top
);
  import mstep_pkg::*;

  logic [WIDTH-1:0] pp_d, y_d, a_d, b_q, b_d;
  logic [WIDTH-1:0] shifted, addend, sum;
  mstep_cc_t        cc_q, cc_d;

  // One multiply step: shift the sign-style bit into the partial product,
  // add the multiplicand when the multiplier LSB is set (never on the
  // closing shift), and rotate the partial-product LSB into the multiplier.
  always_comb begin
    shifted = {cc_q.neg ^ cc_q.ovf, pp[WIDTH-1:1]};
    addend  = (yreg[0] && !final_step) ? b_q : '0;
    sum     = shifted + addend;
  end

  always_comb begin
    pp_d = pp;
    y_d  = yreg;
    a_d  = a_hold;
    b_d  = b_q;
    cc_d = cc_q;
    if (load) begin
      pp_d = '0;
      y_d  = a_in;
      a_d  = a_in;
      b_d  = b_in;
      cc_d = '{neg: 1'b0, ovf: 1'b0};
    end else if (step_en) begin
      pp_d     = sum;
      y_d      = {pp[0], yreg[WIDTH-1:1]};
      cc_d.neg = sum[WIDTH-1];
      cc_d.ovf = (shifted[WIDTH-1] == addend[WIDTH-1]) &&
                 (sum[WIDTH-1] != shifted[WIDTH-1]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pp     <= '0;
      yreg   <= '0;
      a_hold <= '0;
      b_q    <= '0;
      cc_q   <= '0;
    end else begin
      pp     <= pp_d;
      yreg   <= y_d;
      a_hold <= a_d;
      b_q    <= b_d;
      cc_q   <= cc_d;
    end
  end

  assign b_top = b_q[WIDTH-1];

endmodule

// File: rtl/mstep_fixup.sv
module mstep_fixup #(
  parameter int WIDTH      = 32,
  parameter int SHORT_BITS = 12
) (
  input  logic             short_q,
  input  logic [WIDTH-1:0] pp,
  input  logic [WIDTH-1:0] yreg,
  input  logic [WIDTH-1:0] a_hold,
  input  logic             b_top,
  output logic [WIDTH-1:0] hi_nx,
  output logic [WIDTH-1:0] lo_nx
);
  localparam int LOW_SHIFT = WIDTH - SHORT_BITS;

  logic [WIDTH-1:0] comp;

  always_comb begin
    comp = a_hold & {WIDTH{b_top}};
    if (short_q) begin
      hi_nx = '0;
      lo_nx = (pp << SHORT_BITS) | (yreg >> LOW_SHIFT);
    end else begin
      hi_nx = pp + comp;
      lo_nx = yreg;
    end
  end

endmodule

// File: rtl/mstep_mul.sv
module mstep_mul #(
  parameter int WIDTH      = 32,
  parameter int SHORT_BITS = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] prod_hi,
  output logic [WIDTH-1:0] prod_lo,
  output logic             zero_flag,
  output logic             ovf_flag
);
  logic             rst_meta_n, rst_sync_n;
  logic             short_sel, load, step_en, final_step, fix_en, short_q, b_top;
  logic [WIDTH-1:0] pp, yreg, a_hold, hi_nx, lo_nx;
  logic [WIDTH-1:0] hi_d, lo_d;
  logic             zero_d, ovf_d, done_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  assign short_sel = (((op_a | op_b) >> SHORT_BITS) == '0);

  mstep_ctrl #(.WIDTH(WIDTH), .SHORT_BITS(SHORT_BITS)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start     (start),
    .short_sel (short_sel),
    .load      (load),
    .step_en   (step_en),
    .final_step(final_step),
    .fix_en    (fix_en),
    .short_q   (short_q),
    .busy      (busy)
  );

  mstep_step #(.WIDTH(WIDTH)) u_step (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load      (load),
    .step_en   (step_en),
    .final_step(final_step),
    .a_in      (op_a),
    .b_in      (op_b),
    .pp        (pp),
    .yreg      (yreg),
    .a_hold    (a_hold),
    .b_top     (b_top)
  );

  mstep_fixup #(.WIDTH(WIDTH), .SHORT_BITS(SHORT_BITS)) u_fix (
    .short_q(short_q),
    .pp     (pp),
    .yreg   (yreg),
    .a_hold (a_hold),
    .b_top  (b_top),
    .hi_nx  (hi_nx),
    .lo_nx  (lo_nx)
  );

  always_comb begin
    hi_d   = prod_hi;
    lo_d   = prod_lo;
    zero_d = zero_flag;
    ovf_d  = ovf_flag;
    done_d = fix_en;
    if (fix_en) begin
      hi_d   = hi_nx;
      lo_d   = lo_nx;
      zero_d = (hi_nx == '0);
      ovf_d  = (hi_nx != '0);
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      prod_hi   <= '0;
      prod_lo   <= '0;
      zero_flag <= 1'b1;
      ovf_flag  <= 1'b0;
      done      <= 1'b0;
    end else begin
      prod_hi   <= hi_d;
      prod_lo   <= lo_d;
      zero_flag <= zero_d;
      ovf_flag  <= ovf_d;
      done      <= done_d;
    end
  end

endmodule

// File: rtl/mstep_mul_chk.sv
module mstep_mul_chk #(
  parameter int WIDTH      = 32,
  parameter int SHORT_BITS = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic             busy,
  input logic             done,
  input logic [WIDTH-1:0] prod_hi,
  input logic [WIDTH-1:0] prod_lo,
  input logic             zero_flag,
  input logic             ovf_flag
);
  localparam int LAT_W     = $clog2(WIDTH + 4) + 1;
  localparam int LAT_SHORT = SHORT_BITS + 2;
  localparam int LAT_LONG  = WIDTH + 2;

  logic [WIDTH-1:0]   ref_a, ref_b;
  logic               ref_short;
  logic [LAT_W-1:0]   lat_q;
  logic [2*WIDTH-1:0] ref_prod;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_a     <= '0;
      ref_b     <= '0;
      ref_short <= 1'b0;
      lat_q     <= '0;
    end else if (start && !busy) begin
      ref_a     <= op_a;
      ref_b     <= op_b;
      ref_short <= (((op_a | op_b) >> SHORT_BITS) == '0);
      lat_q     <= '0;
    end else if (busy) begin
      lat_q <= lat_q + 1'b1;
    end
  end

  assign ref_prod = {{WIDTH{1'b0}}, ref_a} * {{WIDTH{1'b0}}, ref_b};

  p_product_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ({prod_hi, prod_lo} == ref_prod));

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat_q == (ref_short ? LAT_W'(LAT_SHORT) : LAT_W'(LAT_LONG))));

  p_short_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ref_short) |-> (prod_hi == '0 && zero_flag));

  p_zero_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    zero_flag == (prod_hi == '0));

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag == !zero_flag);

  p_busy_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  p_busy_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && lat_q < LAT_W'(LAT_SHORT - 1)) |=> busy);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(prod_hi) && $stable(prod_lo) && $stable(zero_flag)));

endmodule

bind mstep_mul mstep_mul_chk #(.WIDTH(WIDTH), .SHORT_BITS(SHORT_BITS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .start    (start),
  .op_a     (op_a),
  .op_b     (op_b),
  .busy     (busy),
  .done     (done),
  .prod_hi  (prod_hi),
  .prod_lo  (prod_lo),
  .zero_flag(zero_flag),
  .ovf_flag (ovf_flag)
);

// File: tb/mstep_mul_tb.sv
module mstep_mul_tb;
  localparam int W = 32;
  localparam int NVEC = 10;

  // {op_a, op_b}
  localparam logic [63:0] VEC [NVEC] = '{
    {32'h0000_0000, 32'h0000_0000},
    {32'h0000_0003, 32'h0000_0005},
    {32'h0000_0FFF, 32'h0000_0FFF},
    {32'h0000_1000, 32'h0000_0001},
    {32'h0000_0001, 32'h0000_1000},
    {32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {32'h8000_0000, 32'h0000_0002},
    {32'h0000_0002, 32'h8000_0000},
    {32'h1234_5678, 32'h9ABC_DEF0},
    {32'h0000_0FFF, 32'h0000_1000}
  };

  logic         clk, rst_n, start;
  logic [W-1:0] op_a, op_b;
  logic         busy, done, zero_flag, ovf_flag;
  logic [W-1:0] prod_hi, prod_lo;

  int errors = 0;
  int checks = 0;
  int cyc    = 0;

  mstep_mul u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
    .busy(busy), .done(done), .prod_hi(prod_hi), .prod_lo(prod_lo),
    .zero_flag(zero_flag), .ovf_flag(ovf_flag)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Start one multiply, return latency (clocks after the accepting edge).
  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                        input int spur_at, output int lat, output logic busy_seen);
    @(negedge clk);
    op_a  = a;
    op_b  = b;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    busy_seen = busy;
    lat = 0;
    do begin
      if (lat == spur_at) begin
        op_a  = ~a;
        op_b  = b ^ 32'h5555_0001;
        start = 1'b1;
      end
      @(posedge clk);
      lat = lat + 1;
      @(negedge clk);
      start = 1'b0;
    end while (!done && lat < 200);
  endtask

  initial begin
    int lat;
    logic bs;
    logic [63:0] held;
    rst_n = 1'b0;
    start = 1'b0;
    op_a  = '0;
    op_b  = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 busy", 64'(busy), 64'd0);
    chk("R9 done", 64'(done), 64'd0);
    chk("R9 product", {prod_hi, prod_lo}, 64'd0);
    chk("R9 flags", 64'({zero_flag, ovf_flag}), 64'b10);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      logic [W-1:0] a, b;
      logic [63:0] exp_p;
      logic sh;
      a = VEC[i][63:32];
      b = VEC[i][31:0];
      exp_p = 64'(a) * 64'(b);
      sh = (((a | b) >> 12) == 0);
      run_op(a, b, -1, lat, bs);
      chk((a[31] || b[31]) ? "R5 product" : "R1 product", {prod_hi, prod_lo}, exp_p);
      chk("R2 latency", 64'(lat), sh ? 64'd14 : 64'd34);
      chk("R4 zero flag", 64'(zero_flag), 64'(exp_p[63:32] == 0));
      chk("R4 ovf flag", 64'(ovf_flag), 64'(exp_p[63:32] != 0));
      chk("R7 busy during run", 64'(bs), 64'd1);
      chk("R7 busy low at done", 64'(busy), 64'd0);
      if (sh) chk("R3 short high word", {31'd0, zero_flag, prod_hi}, {31'd0, 1'b1, 32'd0});
      @(negedge clk);
      chk("R7 done one cycle", 64'(done), 64'd0);
    end

    // R6: start while busy is ignored
    run_op(32'hDEAD_BEEF, 32'h0001_0003, 5, lat, bs);
    chk("R6 product unchanged", {prod_hi, prod_lo}, 64'(32'hDEAD_BEEF) * 64'(32'h0001_0003));
    chk("R6 latency unchanged", 64'(lat), 64'd34);
    held = {prod_hi, prod_lo};
    repeat (4) begin
      @(negedge clk);
      chk("R6 no second run", 64'({busy, done}), 64'd0);
    end
    // R8: outputs hold while idle and during a new run until done
    chk("R8 hold idle", {prod_hi, prod_lo}, held);
    @(negedge clk);
    op_a = 32'h0000_0007; op_b = 32'h0000_0009; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    chk("R8 hold during run", {prod_hi, prod_lo}, held);
    repeat (10) @(negedge clk);
    chk("R3 short result", {prod_hi, prod_lo}, 64'd63);

    // R9: reset in the middle of a run
    @(negedge clk);
    op_a = 32'hFFFF_0000; op_b = 32'h0000_FFFF; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (6) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R9 mid-run reset busy", 64'({busy, done}), 64'd0);
    chk("R9 mid-run reset product", {prod_hi, prod_lo}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run_op(32'h8000_0001, 32'h8000_0001, -1, lat, bs);
    chk("R5 after reset", {prod_hi, prod_lo}, 64'(32'h8000_0001) * 64'(32'h8000_0001));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule